// File: doc/BRIEF.md
# Serial Register Slave with Chained Select

This block gives a host processor access to a bank of byte-wide control registers over a four-wire serial link: clock, active-low select, data in and data out. Every access is framed by the select line. The first byte holds a direction flag in its most significant bit (1 = read, 0 = write) and a 7-bit register address in the remaining bits. The byte after it carries the register value. All bytes move most significant bit first. The host changes data on falling serial-clock edges and the block samples on rising ones. The serial clock idles high.

Both serial inputs are resampled into a faster system clock, and edges are detected there. A falling edge on the select line always restarts framing, which clears any framing error. Register 0 holds the block's own settings. Bit 6 chooses when the data output is released after a read: it releases on the first falling serial edge after the last data bit, or else holds until select rises. Bit 7 turns on chained operation. In chained mode a leading selector byte comes before each access. The block only acts when bit 0 of the selector byte is 1. It passes the selector byte on, shifted right by one, through a pass-through output. Up to eight blocks can then share one select line, each one using the lowest remaining selector bit.

A read port into the register file lets the surrounding logic see the stored values.

Top module: `spi_regslave`

## Requirements
- R1: After reset, every register reads 0, `sdo_oe` is 0 and both setting bits in register 0 are 0.
- R2: A frame whose command byte has bit 7 = 0 writes the data byte into the register named by command bits 6..0. The write commits only once the eighth data bit has been sampled.
- R3: A frame whose command byte has bit 7 = 1 drives the addressed register on `sdo`, MSB first. Each bit is updated on a falling serial edge and is valid at the rising edge that samples it. `sdo_oe` is 1 over all eight data bits.
- R4: During the data byte of a read, `sdi` has no effect on any register.
- R5: With register 0 bit 6 = 1, `sdo_oe` drops on the falling serial edge that follows the last data bit of a read. With bit 6 = 0 it stays high until select rises.
- R6: A rising edge on `cs_n` always clears `sdo_oe`.
- R7: `sdo_oe` stays 0 for the whole of a write frame.
- R8: A falling edge on `cs_n` throws away any partial byte, and the next bits are treated as a fresh frame.
- R9: If `cs_n` rises before the eighth data bit, no register changes. This includes a rise that is detected in the same system-clock cycle as the final rising serial edge.
- R10: With register 0 bit 7 = 1 (read at each falling select edge), a frame is selector byte, command byte, data byte. The access takes effect only when selector bit 0 is 1.
- R11: `sdo_thru` presents the selector byte shifted right by one (a 0 first, then selector bits 7..1, one bit per serial period). After that it passes command and data bits unchanged. Outside chained mode it simply follows `sdi`.
- R12: A block whose selector bit 0 is 0 neither writes a register nor drives `sdo_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial read data, meaningful while `sdo_oe` is 1 |
| sdo_oe | output | 1 | Output enable for the external data-out pad driver |
| sdo_thru | output | 1 | Serial pass-through toward the next block in a chain |
| rf_raddr | input | 7 | Register-file read address for the surrounding logic |
| rf_rdata | output | 8 | Register-file read data |

## Verification
Two things can arrive in the same system-clock cycle: the rising serial edge that completes a write's data byte, and the rising edge of select. The bench provokes this by changing `sclk` and `cs_n` in the same time step on the final bit. Both inputs pass through synchronizers of equal depth, so the two edges surface together. The frame must then be judged as aborted, and a read-back through the register port has to show the old value. A second overlap is the falling serial edge after a read's last bit coinciding with an early-release setting that was written earlier. That case is judged by sampling `sdo_oe` before select rises.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = BYTE_W - 1;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int CNT_W     = $clog2(BYTE_W);
    localparam int MODE_ADDR = 0;
    localparam int EARLY_BIT = 6;
    localparam int DAISY_BIT = 7;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CSB,
        PH_CMD,
        PH_DAT,
        PH_DONE
    } phase_t;

    typedef struct packed {
        logic sclk_rise;
        logic sclk_fall;
        logic cs_rise;
        logic cs_fall;
    } evt_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_t;

    typedef struct packed {
        logic daisy;
        logic early;
    } mode_t;

    function automatic mode_t decode_mode(input logic [BYTE_W-1:0] r);
        mode_t m;
        m.daisy = r[DAISY_BIT];
        m.early = r[EARLY_BIT];
        return m;
    endfunction

    function automatic logic cmd_is_read(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1];
    endfunction

endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
    parameter int       W       = 3,
    parameter int       STAGES  = 2,
    parameter logic     RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {(STAGES*W){RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_rs_edge.sv
module spi_rs_edge
    import spi_rs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sclk_s,
    input  logic cs_s,
    output evt_t evt
);
    logic sclk_q;
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b1;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            cs_q   <= cs_s;
        end
    end

    always_comb begin
        evt.sclk_rise = sclk_s & ~sclk_q;
        evt.sclk_fall = ~sclk_s & sclk_q;
        evt.cs_rise   = cs_s & ~cs_q;
        evt.cs_fall   = ~cs_s & cs_q;
    end
endmodule

// File: rtl/spi_rs_regfile.sv
module spi_rs_regfile
    import spi_rs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_t           wr,
    input  logic [AW-1:0] ra_a,
    output logic [DW-1:0] rd_a,
    input  logic [AW-1:0] ra_b,
    output logic [DW-1:0] rd_b,
    output mode_t         mode
);
    localparam int N = 1 << AW;

    logic [DW-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                mem[i] <= '0;
            end
        end else if (wr.en) begin
            mem[wr.addr] <= wr.data;
        end
    end

    assign rd_a = mem[ra_a];
    assign rd_b = mem[ra_b];
    assign mode = decode_mode(mem[MODE_ADDR]);
endmodule

// File: rtl/spi_rs_frame.sv
module spi_rs_frame
    import spi_rs_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  evt_t          evt,
    input  logic          cs_s,
    input  logic          sdi_s,
    input  mode_t         mode,
    output logic [AW-1:0] rd_addr,
    input  logic [BW-1:0] rd_data,
    output wr_t           wr,
    output logic          sdo,
    output logic          sdo_oe,
    output logic          sdo_thru
);
    localparam logic [CW-1:0] LAST = CW'(BW - 1);

    phase_t        phase;
    logic [CW-1:0] cnt;
    logic [BW-1:0] shin;
    logic [BW-1:0] shout;
    logic [BW-1:0] nxt;
    logic          sel;
    logic          is_rd;
    logic          dly;
    logic          shifting;

    assign nxt      = {shin[BW-2:0], sdi_s};
    assign shifting = (phase == PH_CSB) || (phase == PH_CMD) || (phase == PH_DAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            shin    <= '0;
            shout   <= '0;
            sel     <= 1'b0;
            is_rd   <= 1'b0;
            rd_addr <= '0;
            dly     <= 1'b0;
            sdo_oe  <= 1'b0;
            wr      <= '0;
        end else begin
            wr.en <= 1'b0;
            if (evt.cs_rise) begin
                phase  <= PH_IDLE;
                sdo_oe <= 1'b0;
            end else if (evt.cs_fall) begin
                phase  <= mode.daisy ? PH_CSB : PH_CMD;
                cnt    <= '0;
                sel    <= ~mode.daisy;
                is_rd  <= 1'b0;
                dly    <= 1'b0;
                sdo_oe <= 1'b0;
            end else if (!cs_s) begin
                if (evt.sclk_rise && shifting) begin
                    shin <= nxt;
                    cnt  <= cnt + 1'b1;
                    if (phase == PH_CSB) begin
                        dly <= sdi_s;
                    end
                    if (cnt == LAST) begin
                        case (phase)
                            PH_CSB: begin
                                sel   <= nxt[0];
                                phase <= PH_CMD;
                            end
                            PH_CMD: begin
                                is_rd   <= cmd_is_read(nxt);
                                rd_addr <= nxt[AW-1:0];
                                phase   <= PH_DAT;
                            end
                            default: begin
                                if (sel && !is_rd) begin
                                    wr.en   <= 1'b1;
                                    wr.addr <= rd_addr;
                                    wr.data <= nxt;
                                end
                                phase <= PH_DONE;
                            end
                        endcase
                    end
                end else if (evt.sclk_fall) begin
                    if (phase == PH_DAT && sel && is_rd) begin
                        if (!sdo_oe) begin
                            sdo_oe <= 1'b1;
                            shout  <= rd_data;
                        end else begin
                            shout <= {shout[BW-2:0], 1'b0};
                        end
                    end else if (phase == PH_DONE && mode.early) begin
                        sdo_oe <= 1'b0;
                    end
                end
            end
        end
    end

    assign sdo      = sdo_oe & shout[BW-1];
    assign sdo_thru = (phase == PH_CSB) ? dly : sdi_s;
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
    import spi_rs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int AW          = ADDR_W,
    parameter int DW          = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic          sdi,
    output logic          sdo,
    output logic          sdo_oe,
    output logic          sdo_thru,
    input  logic [AW-1:0] rf_raddr,
    output logic [DW-1:0] rf_rdata
);
    logic [2:0]    pins_s;
    evt_t          evt;
    mode_t         mode;
    wr_t           wr_req;
    logic          wr_en;
    logic [AW-1:0] fr_addr;
    logic [DW-1:0] fr_data;

    spi_rs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sclk, cs_n, sdi}),
        .q   (pins_s)
    );

    spi_rs_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sclk_s (pins_s[2]),
        .cs_s   (pins_s[1]),
        .evt    (evt)
    );

    spi_rs_frame #(.BW(DW), .AW(AW)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .cs_s     (pins_s[1]),
        .sdi_s    (pins_s[0]),
        .mode     (mode),
        .rd_addr  (fr_addr),
        .rd_data  (fr_data),
        .wr       (wr_req),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe),
        .sdo_thru (sdo_thru)
    );

    spi_rs_regfile #(.AW(AW), .DW(DW)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr_req),
        .ra_a (fr_addr),
        .rd_a (fr_data),
        .ra_b (rf_raddr),
        .rd_b (rf_rdata),
        .mode (mode)
    );

    assign wr_en = wr_req.en;
endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk
    import spi_rs_pkg::*;
(
    input logic clk,
    input logic rst,
    input evt_t evt,
    input logic wr_en,
    input logic sdo_oe
);
    AST_CS_RISE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        evt.cs_rise |=> !sdo_oe);                                      // R6

    AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        evt.cs_rise |=> !wr_en);                                       // R9

    AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);                                             // R2

    AST_OE_ON_EDGES: assert property (@(posedge clk) disable iff (rst)
        !(evt.sclk_fall || evt.cs_rise || evt.cs_fall) |=> $stable(sdo_oe)); // R5

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !sdo_oe);                                            // R7
endmodule

bind spi_regslave spi_regslave_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt),
    .wr_en  (wr_en),
    .sdo_oe (sdo_oe)
);

// File: tb/spi_regslave_test.sv
module spi_regslave_test;

    localparam int HALF = 80;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b1;
    logic       cs_n = 1'b1;
    logic       sdi = 1'b1;
    logic       sdo;
    logic       sdo_oe;
    logic       sdo_thru;
    logic [6:0] rf_raddr = '0;
    logic [7:0] rf_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        logic [7:0] v;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] act_q[$];

    spi_regslave uut (
        .clk      (clk),
        .rst      (rst),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .sdi      (sdi),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe),
        .sdo_thru (sdo_thru),
        .rf_raddr (rf_raddr),
        .rf_rdata (rf_rdata)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    // monitor: pairs expected read bytes with captured ones
    initial begin
        item_t      e;
        logic [7:0] a;
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && act_q.size() > 0) begin
                e = exp_q.pop_front();
                a = act_q.pop_front();
                check(e.req, a, e.v);
            end
        end
    end

    task automatic peek(input logic [6:0] a, output logic [7:0] v);
        rf_raddr = a;
        #8;
        v = rf_rdata;
    endtask

    task automatic send_bits(input logic [7:0] tx, input int n,
                             output logic [7:0] rx, output logic [7:0] th,
                             output logic [7:0] oev);
        rx = '0; th = '0; oev = '0;
        for (int i = 7; i >= 8 - n; i--) begin
            sclk = 1'b0;
            sdi  = tx[i];
            #(HALF);
            rx[i]  = sdo;
            th[i]  = sdo_thru;
            oev[i] = sdo_oe;
            sclk = 1'b1;
            #(HALF);
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        #(HALF);
    endtask

    task automatic cs_high();
        cs_n = 1'b1;
        #(2 * HALF);
    endtask

    task automatic do_write(input bit dc, input logic [7:0] csb, input logic [6:0] a,
                            input logic [7:0] d, output logic [7:0] th_csb,
                            output logic [7:0] th_cmd, output logic [7:0] th_dat);
        logic [7:0] rx, oev, oe_all;
        th_csb = '0;
        oe_all = '0;
        cs_low();
        if (dc) begin
            send_bits(csb, 8, rx, th_csb, oev);
            oe_all |= oev;
        end
        send_bits({1'b0, a}, 8, rx, th_cmd, oev);
        oe_all |= oev;
        send_bits(d, 8, rx, th_dat, oev);
        oe_all |= oev;
        check("R7 oe during write", oe_all, 8'h00);
        cs_high();
    endtask

    task automatic do_read(input bit dc, input logic [7:0] csb, input logic [6:0] a,
                           input logic [7:0] din, input logic [7:0] exp,
                           input bit drive, input bit early, input string req,
                           output logic [7:0] th_csb, output logic [7:0] th_cmd,
                           output logic [7:0] th_dat);
        logic [7:0] rx, oev;
        item_t it;
        th_csb = '0;
        cs_low();
        if (dc) send_bits(csb, 8, rx, th_csb, oev);
        send_bits({1'b1, a}, 8, rx, th_cmd, oev);
        send_bits(din, 8, rx, th_dat, oev);
        if (drive) begin
            it.req = req;
            it.v   = exp;
            exp_q.push_back(it);
            act_q.push_back(rx);
            check("R3 oe over data byte", oev, 8'hFF);
        end else begin
            check("R12 unselected read keeps oe low", oev, 8'h00);
        end
        sclk = 1'b0;
        #(HALF);
        check("R5 oe after trailing falling edge", {7'b0, sdo_oe}, {7'b0, drive && !early});
        sclk = 1'b1;
        #(HALF);
        cs_high();
        check("R6 oe after cs rise", {7'b0, sdo_oe}, 8'h00);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, t0, t1, t2, rx, th, oev;

        #40;
        rst = 1'b0;
        #(2 * HALF);

        // R1: reset state
        check("R1 oe at reset", {7'b0, sdo_oe}, 8'h00);
        peek(7'd0, v);   check("R1 reg0 at reset", v, 8'h00);
        peek(7'd5, v);   check("R1 reg5 at reset", v, 8'h00);
        peek(7'd127, v); check("R1 reg127 at reset", v, 8'h00);

        // R2 writes, R11 plain pass-through
        do_write(1'b0, 8'h00, 7'd5, 8'hA5, t0, t1, t2);
        check("R11 thru follows cmd byte", t1, 8'h05);
        check("R11 thru follows data byte", t2, 8'hA5);
        peek(7'd5, v);   check("R2 reg5 written", v, 8'hA5);
        do_write(1'b0, 8'h00, 7'd127, 8'h3C, t0, t1, t2);
        peek(7'd127, v); check("R2 reg127 written", v, 8'h3C);

        // R3 reads with late release, R4 sdi ignored in data byte
        do_read(1'b0, 8'h00, 7'd5, 8'hFF, 8'hA5, 1'b1, 1'b0, "R3 read reg5", t0, t1, t2);
        do_read(1'b0, 8'h00, 7'd127, 8'h00, 8'h3C, 1'b1, 1'b0, "R3 read reg127", t0, t1, t2);
        peek(7'd5, v);   check("R4 reg5 unchanged by read sdi", v, 8'hA5);
        peek(7'd127, v); check("R4 reg127 unchanged by read sdi", v, 8'h3C);

        // R5 early release
        do_write(1'b0, 8'h00, 7'd0, 8'h40, t0, t1, t2);
        do_read(1'b0, 8'h00, 7'd127, 8'h55, 8'h3C, 1'b1, 1'b1, "R5 read early mode", t0, t1, t2);

        // R9 aborts
        cs_low();
        send_bits(8'h09, 8, rx, th, oev);
        send_bits(8'h77, 4, rx, th, oev);
        cs_high();
        peek(7'd9, v); check("R9 abort mid-data", v, 8'h00);
        cs_low();
        send_bits(8'h09, 8, rx, th, oev);
        send_bits(8'h77, 7, rx, th, oev);
        sclk = 1'b0; sdi = 1'b1;
        #(HALF);
        sclk = 1'b1; cs_n = 1'b1;
        #(2 * HALF);
        peek(7'd9, v); check("R9 cs rise with last sclk rise", v, 8'h00);

        // R8 resync after partial byte
        cs_low();
        send_bits(8'hFF, 3, rx, th, oev);
        cs_n = 1'b1;
        #(HALF);
        do_write(1'b0, 8'h00, 7'd9, 8'h5A, t0, t1, t2);
        peek(7'd9, v); check("R8 write after resync", v, 8'h5A);

        // R10 chained mode on, late release
        do_write(1'b0, 8'h00, 7'd0, 8'h80, t0, t1, t2);
        do_write(1'b1, 8'h01, 7'd5, 8'h66, t0, t1, t2);
        check("R11 thru selector 01 shifted", t0, 8'h00);
        check("R11 thru cmd unchanged", t1, 8'h05);
        check("R11 thru data unchanged", t2, 8'h66);
        peek(7'd5, v); check("R10 selected chained write", v, 8'h66);

        do_write(1'b1, 8'h02, 7'd5, 8'h11, t0, t1, t2);
        check("R11 thru selector 02 shifted", t0, 8'h01);
        peek(7'd5, v); check("R12 unselected write ignored", v, 8'h66);

        do_read(1'b1, 8'h03, 7'd5, 8'hC3, 8'h66, 1'b1, 1'b0, "R10 chained read", t0, t1, t2);
        check("R11 thru selector 03 shifted", t0, 8'h01);
        check("R11 thru read cmd unchanged", t1, 8'h85);
        check("R11 thru read data unchanged", t2, 8'hC3);

        do_read(1'b1, 8'hFE, 7'd5, 8'h00, 8'h00, 1'b0, 1'b0, "R12 unselected read", t0, t1, t2);
        check("R11 thru selector FE shifted", t0, 8'h7F);

        #(4 * HALF);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule